// File: doc/BRIEF.md
# Quad-SPI to on-chip RAM burst loader with processor stall

The block moves a contiguous run of bytes from an external quad-SPI memory into on-chip single-port RAM with no help from the processor. Software supplies three values: a 24-bit source address in the serial memory, a destination address in the RAM, and a byte count. It then pulses `start`. The serial memory is also used by the graphics engine for texture reads. For that reason the request waits while `gpu_busy` is high, which means the graphics engine still owns the memory for its current frame. The burst starts only once `gpu_busy` is seen low.

A burst begins with a header. The loader drops chip select and sends eight nibbles on the four data lines: a read command followed by the source address. A fixed number of turnaround cycles follows. The memory then returns data on both clock edges. The two nibbles captured per cycle, one for each edge, are joined into one byte, so the RAM receives one write on every clock of the data phase. The RAM port is busy on each of those cycles, so the processor cores cannot fetch instructions. The loader holds `cpu_stall` high for the whole burst. On the cycle after the last write, it releases chip select, drops the stall and pulses `done`.

Top module: `qpi_burst_loader`

## Requirements
- R1: After reset, `qpi_cs_n` is 1, and `cpu_stall`, `qpi_dq_oe`, `ram_we` and `done` are all 0.
- R2: A `start` pulse with a nonzero `length` latches `src_addr`, `dst_addr` and `length`. The request then stays pending, with chip select high and no stall, for as long as `gpu_busy` is 1. The header begins on the cycle after `gpu_busy` is sampled 0.
- R3: The header lasts 8 cycles. During it `qpi_cs_n` is 0 and `qpi_dq_oe` is 1. `qpi_dq_out` carries the 32-bit word {8'hEB, src_addr}, most significant nibble first. `qpi_dq_oe` is never 1 outside the header.
- R4: After the header come DUMMY (default 4) turnaround cycles. During these, chip select stays low, `qpi_dq_oe` is 0 and `ram_we` is 0.
- R5: Next, `ram_we` is 1 on exactly `length` consecutive cycles. Write k goes to address dst_addr+k with data {qpi_dq_hi, qpi_dq_lo}. The rising-edge nibble is the upper half of the byte.
- R6: `cpu_stall` is 1 from the first header cycle through the last write, which is exactly 8+DUMMY+length cycles. It is 1 whenever `ram_we` is 1.
- R7: On the cycle after the final write, `qpi_cs_n` returns to 1 and `cpu_stall` to 0. `done` is 1 for exactly that one cycle.
- R8: A `start` pulse is ignored while a request is pending or a burst is running. A `start` pulse with `length` 0 is ignored: no stall, no chip select and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a copy |
| src_addr | input | 24 | Byte address in the serial memory |
| dst_addr | input | DST_W | First RAM byte address |
| length | input | LEN_W | Number of bytes to copy |
| gpu_busy | input | 1 | Graphics engine still owns the serial memory |
| qpi_cs_n | output | 1 | Serial memory chip select, active low |
| qpi_dq_out | output | 4 | Header nibble driven toward the memory |
| qpi_dq_oe | output | 1 | Output enable for the four data lines |
| qpi_dq_hi | input | 4 | Nibble captured on the rising edge |
| qpi_dq_lo | input | 4 | Nibble captured on the falling edge |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | DST_W | RAM write address |
| ram_wdata | output | 8 | RAM write byte |
| cpu_stall | output | 1 | Freeze for all processor cores |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle: acceptance of a new request and the final RAM write of a running burst. The bench provokes this by pulsing `start`, with a different destination and length, on exactly the cycle in which the last byte is written. It then confirms three things: only the original count of writes occurred, the second destination area is untouched, and a single `done` appeared. A second collision test issues two requests while `gpu_busy` is high and checks that only the first one's data lands once the graphics engine lets go.

// File: rtl/qbl_pkg.sv
package qbl_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PEND  = 3'd1,
    S_HDR   = 3'd2,
    S_DUMMY = 3'd3,
    S_DATA  = 3'd4
  } qbl_state_t;

  localparam int HDR_NIBBLES = 8;
  localparam int SRC_W       = 24;
endpackage

// File: rtl/qbl_hdr_mux.sv
module qbl_hdr_mux
  import qbl_pkg::*;
#(
  parameter logic [7:0] READ_CMD = 8'hEB
) (
  input  logic [SRC_W-1:0] src,
  input  logic [2:0]       idx,
  output logic [3:0]       nib
);
  localparam int HDR_W = 8 + SRC_W;

  logic [HDR_W-1:0] header;
  logic [3:0]       nibs [HDR_NIBBLES];

  assign header = {READ_CMD, src};

  // nibble 0 is the most significant one, sent first
  for (genvar g = 0; g < HDR_NIBBLES; g++) begin : g_nib
    assign nibs[g] = header[HDR_W-1-4*g -: 4];
  end

  assign nib = nibs[idx];
endmodule

// File: rtl/qbl_byte_pack.sv
module qbl_byte_pack #(
  parameter int DST_W = 17
) (
  input  logic             in_data,
  input  logic [3:0]       dq_hi,
  input  logic [3:0]       dq_lo,
  input  logic [DST_W-1:0] dst,
  output logic             ram_we,
  output logic [DST_W-1:0] ram_addr,
  output logic [7:0]       ram_wdata
);
  // rising-edge nibble forms the upper half of the byte
  assign ram_we    = in_data;
  assign ram_addr  = dst;
  assign ram_wdata = {dq_hi, dq_lo};
endmodule

// File: rtl/qbl_ctrl.sv
module qbl_ctrl
  import qbl_pkg::*;
#(
  parameter int DST_W = 17,
  parameter int LEN_W = 17,
  parameter int DUMMY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SRC_W-1:0] src_addr,
  input  logic [DST_W-1:0] dst_addr,
  input  logic [LEN_W-1:0] length,
  input  logic             gpu_busy,
  output logic             active,
  output logic             in_hdr,
  output logic             in_data,
  output logic [2:0]       hdr_idx,
  output logic [SRC_W-1:0] src,
  output logic [DST_W-1:0] dst,
  output logic             done
);
  localparam int MAXC  = (DUMMY > HDR_NIBBLES) ? DUMMY : HDR_NIBBLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_NIBBLES - 1);
  localparam logic [CNT_W-1:0] DUM_LAST = CNT_W'(DUMMY - 1);

  qbl_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [DST_W-1:0] dst_q, dst_d;
  logic [SRC_W-1:0] src_q, src_d;
  logic             done_q, done_d;
  logic             par_en, cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    dst_d   = dst_q;
    src_d   = src_q;
    done_d  = 1'b0;
    par_en  = 1'b0;
    cnt_en  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start && (length != '0)) begin
          state_d = S_PEND;
          src_d   = src_addr;
          dst_d   = dst_addr;
          rem_d   = length;
          par_en  = 1'b1;
        end
      end
      S_PEND: begin
        if (!gpu_busy) begin
          state_d = S_HDR;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      S_HDR: begin
        cnt_en = 1'b1;
        if (cnt_q == HDR_LAST) begin
          state_d = S_DUMMY;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_DUMMY: begin
        cnt_en = 1'b1;
        if (cnt_q == DUM_LAST) begin
          state_d = S_DATA;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_DATA: begin
        par_en = 1'b1;
        rem_d  = rem_q - 1'b1;
        dst_d  = dst_q + 1'b1;
        if (rem_q == LEN_W'(1)) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dst_q <= '0;
      src_q <= '0;
    end else if (par_en) begin
      rem_q <= rem_d;
      dst_q <= dst_d;
      src_q <= src_d;
    end
  end

  assign in_hdr  = (state_q == S_HDR);
  assign in_data = (state_q == S_DATA);
  assign active  = in_hdr || in_data || (state_q == S_DUMMY);
  assign hdr_idx = cnt_q[2:0];
  assign src     = src_q;
  assign dst     = dst_q;
  assign done    = done_q;
endmodule

// File: rtl/qpi_burst_loader.sv
module qpi_burst_loader
  import qbl_pkg::*;
#(
  parameter int         DST_W    = 17,
  parameter int         LEN_W    = 17,
  parameter int         DUMMY    = 4,
  parameter logic [7:0] READ_CMD = 8'hEB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      src_addr,
  input  logic [DST_W-1:0] dst_addr,
  input  logic [LEN_W-1:0] length,
  input  logic             gpu_busy,
  output logic             qpi_cs_n,
  output logic [3:0]       qpi_dq_out,
  output logic             qpi_dq_oe,
  input  logic [3:0]       qpi_dq_hi,
  input  logic [3:0]       qpi_dq_lo,
  output logic             ram_we,
  output logic [DST_W-1:0] ram_addr,
  output logic [7:0]       ram_wdata,
  output logic             cpu_stall,
  output logic             done
);
  logic             active, in_hdr, in_data;
  logic [2:0]       hdr_idx;
  logic [SRC_W-1:0] src;
  logic [DST_W-1:0] dst;
  logic [3:0]       nib;

  qbl_ctrl #(.DST_W(DST_W), .LEN_W(LEN_W), .DUMMY(DUMMY)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .length   (length),
    .gpu_busy (gpu_busy),
    .active   (active),
    .in_hdr   (in_hdr),
    .in_data  (in_data),
    .hdr_idx  (hdr_idx),
    .src      (src),
    .dst      (dst),
    .done     (done)
  );

  qbl_hdr_mux #(.READ_CMD(READ_CMD)) u_hdr (
    .src (src),
    .idx (hdr_idx),
    .nib (nib)
  );

  qbl_byte_pack #(.DST_W(DST_W)) u_pack (
    .in_data   (in_data),
    .dq_hi     (qpi_dq_hi),
    .dq_lo     (qpi_dq_lo),
    .dst       (dst),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
  );

  assign qpi_cs_n   = ~active;
  assign cpu_stall  = active;
  assign qpi_dq_oe  = in_hdr;
  assign qpi_dq_out = in_hdr ? nib : 4'h0;
endmodule

// File: rtl/qbl_checker.sv
module qbl_checker #(
  parameter int DST_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gpu_busy,
  input logic             qpi_cs_n,
  input logic             qpi_dq_oe,
  input logic             ram_we,
  input logic [DST_W-1:0] ram_addr,
  input logic             cpu_stall,
  input logic             done
);
  // R2: the burst never opens right after the graphics engine was seen busy
  a_r2_wait_gpu: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(qpi_cs_n) |-> !$past(gpu_busy));

  // R3: data lines driven only while selected
  a_r3_oe_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    qpi_dq_oe |-> !qpi_cs_n);

  // R5: consecutive writes step the address by one
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + 1'b1));

  // R6: every write happens under stall
  a_r6_we_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> cpu_stall);

  // R7: completion follows the last write and ends the stall
  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(ram_we) && !cpu_stall && qpi_cs_n));

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind qpi_burst_loader qbl_checker #(.DST_W(DST_W)) u_qbl_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .gpu_busy  (gpu_busy),
  .qpi_cs_n  (qpi_cs_n),
  .qpi_dq_oe (qpi_dq_oe),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .cpu_stall (cpu_stall),
  .done      (done)
);

// File: tb/tb_qpi_burst_loader.sv
`timescale 1ns/1ps
module tb_qpi_burst_loader;
  localparam int DST_W = 10;
  localparam int LEN_W = 10;
  localparam int DUMMY = 4;
  localparam int HDR   = 8;
  localparam int DATA0 = HDR + DUMMY;

  logic             clk, rst_n, start, gpu_busy;
  logic [23:0]      src_addr;
  logic [DST_W-1:0] dst_addr;
  logic [LEN_W-1:0] length;
  logic             qpi_cs_n, qpi_dq_oe, ram_we, cpu_stall, done;
  logic [3:0]       qpi_dq_out, qpi_dq_hi, qpi_dq_lo;
  logic [DST_W-1:0] ram_addr;
  logic [7:0]       ram_wdata;

  int tests = 0;
  int fails = 0;

  qpi_burst_loader #(.DST_W(DST_W), .LEN_W(LEN_W), .DUMMY(DUMMY)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
    .dst_addr(dst_addr), .length(length), .gpu_busy(gpu_busy),
    .qpi_cs_n(qpi_cs_n), .qpi_dq_out(qpi_dq_out), .qpi_dq_oe(qpi_dq_oe),
    .qpi_dq_hi(qpi_dq_hi), .qpi_dq_lo(qpi_dq_lo), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .cpu_stall(cpu_stall),
    .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // serial memory model and observation counters
  int          cyc;
  logic [31:0] hdr_cap;
  logic [7:0]  ram [1 << DST_W];
  int          we_cnt, stall_cnt, done_cnt, done_bad, oe_bad, we_early;
  logic        prev_we;

  always_comb begin
    logic [23:0] a;
    a = hdr_cap[23:0] + 24'(cyc - DATA0);
    qpi_dq_hi = (!qpi_cs_n && cyc >= DATA0) ? mem_byte(a)[7:4] : 4'h0;
    qpi_dq_lo = (!qpi_cs_n && cyc >= DATA0) ? mem_byte(a)[3:0] : 4'h0;
  end

  always @(posedge clk) begin
    if (qpi_cs_n) cyc <= 0;
    else          cyc <= cyc + 1;
    if (!qpi_cs_n && cyc < HDR) hdr_cap <= {hdr_cap[27:0], qpi_dq_out};
    if (ram_we) ram[ram_addr] <= ram_wdata;
    if (ram_we) we_cnt <= we_cnt + 1;
    if (cpu_stall) stall_cnt <= stall_cnt + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (done && (!prev_we || cpu_stall || !qpi_cs_n)) done_bad <= done_bad + 1;
    if (qpi_dq_oe && (qpi_cs_n || cyc >= HDR)) oe_bad <= oe_bad + 1;
    if (ram_we && cyc < DATA0) we_early <= we_early + 1;
    prev_we <= ram_we;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    we_cnt = 0; stall_cnt = 0; done_cnt = 0; done_bad = 0; oe_bad = 0; we_early = 0;
  endtask

  task automatic fill_ram();
    for (int i = 0; i < (1 << DST_W); i++) ram[i] = 8'hC3;
  endtask

  task automatic pulse_start(input logic [23:0] s, input int d, input int n);
    @(negedge clk);
    start = 1'b1; src_addr = s; dst_addr = DST_W'(d); length = LEN_W'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    while (done_cnt == 0 && k < 3000) begin
      @(negedge clk);
      k++;
    end
    check(done_cnt != 0, "R7 done seen", done_cnt, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_data(input string tag, input logic [23:0] s, input int d, input int n);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++)
      if (ram[d + i] != mem_byte(s + 24'(i))) bad++;
    check(bad == 0, {tag, " R5 bytes"}, bad, 0);
    check(ram[d - 1] == 8'hC3 && ram[d + n] == 8'hC3, {tag, " R5 bounds"},
          int'(ram[d + n]), 'hC3);
  endtask

  task automatic t_reset();
    check(qpi_cs_n && !cpu_stall && !qpi_dq_oe && !ram_we && !done, "R1 reset outputs",
          {qpi_cs_n, cpu_stall, qpi_dq_oe, ram_we, done}, 5'b10000);
  endtask

  task automatic t_basic(input logic [23:0] s, input int d, input int n);
    fill_ram();
    clear_mon();
    pulse_start(s, d, n);
    wait_done();
    check(hdr_cap == {8'hEB, s}, "R3 header word", int'(hdr_cap), int'({8'hEB, s}));
    check(oe_bad == 0, "R3 oe window", oe_bad, 0);
    check(we_early == 0, "R4 no write in turnaround", we_early, 0);
    check(we_cnt == n, "R5 write count", we_cnt, n);
    check(stall_cnt == DATA0 + n, "R6 stall cycles", stall_cnt, DATA0 + n);
    check(done_cnt == 1 && done_bad == 0, "R7 done pulse timing", done_bad, 0);
    check_data("basic", s, d, n);
  endtask

  task automatic t_pending();
    fill_ram();
    clear_mon();
    gpu_busy = 1'b1;
    pulse_start(24'h0A1230, 100, 6);
    pulse_start(24'h777777, 300, 9);
    repeat (20) @(negedge clk);
    check(stall_cnt == 0 && qpi_cs_n, "R2 held while gpu busy", stall_cnt, 0);
    gpu_busy = 1'b0;
    wait_done();
    check(we_cnt == 6, "R8 second start ignored while pending", we_cnt, 6);
    check(hdr_cap[23:0] == 24'h0A1230, "R2 latched source", int'(hdr_cap[23:0]), 'h0A1230);
    check_data("pending", 24'h0A1230, 100, 6);
    check(ram[300] == 8'hC3, "R8 ignored destination untouched", int'(ram[300]), 'hC3);
  endtask

  task automatic t_overlap();
    int k;
    fill_ram();
    clear_mon();
    pulse_start(24'h004000, 200, 3);
    k = 0;
    while (!(ram_we && ram_addr == DST_W'(202)) && k < 200) begin
      @(negedge clk);
      k++;
    end
    start = 1'b1; src_addr = 24'h111111; dst_addr = DST_W'(500); length = LEN_W'(4);
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    check(we_cnt == 3, "R8 start on final write ignored", we_cnt, 3);
    check(done_cnt == 1, "R7 single done", done_cnt, 1);
    check(ram[500] == 8'hC3 && !cpu_stall, "R8 no second burst", int'(ram[500]), 'hC3);
    check_data("overlap", 24'h004000, 200, 3);
  endtask

  task automatic t_zero();
    clear_mon();
    pulse_start(24'h123456, 50, 0);
    repeat (25) @(negedge clk);
    check(stall_cnt == 0 && done_cnt == 0 && qpi_cs_n, "R8 zero length ignored",
          stall_cnt + done_cnt, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; gpu_busy = 1'b0;
    src_addr = '0; dst_addr = '0; length = '0;
    cyc = 0; hdr_cap = '0; prev_we = 1'b0;
    we_cnt = 0; stall_cnt = 0; done_cnt = 0; done_bad = 0; oe_bad = 0; we_early = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic(24'hABCDEF, 10, 5);
    t_basic(24'h00FFFE, 700, 1);
    t_basic(24'h3C0000, 40, 64);
    t_pending();
    t_overlap();
    t_zero();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule